// File: doc/BRIEF.md
# Single-Accumulator Processor Core

This block is a compact multicycle processor whose only data register visible to a program is one accumulator. Each instruction word carries an opcode, a mode bit and one word address. Arithmetic always takes the accumulator as its first operand and writes the result back into it. The second operand comes from memory. It is reached either directly through the address field or through a pointer word stored at that address. The pointer route costs one extra memory read before the operand access.

The core talks to a single synchronous, word-addressed memory. It uses that memory for instruction fetch, for pointer reads, for operand reads and for stores. Control flow is limited to sequential execution, one unconditional jump and a halt. Halt stops the core and raises a completion flag. A division by zero does not disturb the accumulator. Instead it latches an error flag that stays set until reset.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted, pc and acc read 0, done and div_err read 0, and mem_we is low.
- R2: The instruction word is laid out as opcode in bits 15:12, indirect flag in bit 11 and address in bits 10:0. The opcodes are 1 LOAD, 2 STORE, 3 ADD, 4 SUB, 5 DIV, 6 JMP and 15 HALT. Opcode 0 and opcodes 7 to 14 do nothing except advance pc by one, two cycles after their fetch begins.
- R3: LOAD sets acc to the operand word. ADD sets acc to acc plus the operand, and SUB sets acc to acc minus the operand. Both wrap modulo 2^16.
- R4: STORE writes acc to the operand address and leaves acc unchanged. A direct STORE occupies 3 cycles, with the write at the end of its third cycle.
- R5: A direct LOAD, ADD, SUB or DIV occupies 4 cycles. pc changes at the second clock edge of the instruction and acc changes at the fourth.
- R6: With the indirect flag set, bits 10:0 of the word at the address field become the operand address. This adds exactly one cycle to LOAD, ADD, SUB, DIV and STORE.
- R7: DIV treats acc and the operand as 16-bit signed values and truncates the quotient toward zero. -32768 divided by -1 gives -32768.
- R8: DIV by a zero operand leaves acc unchanged and sets div_err. div_err then stays set until reset.
- R9: JMP loads pc with the address field and occupies 2 cycles.
- R10: HALT raises done at the end of its second cycle and keeps pc at the address of the HALT word. After that, acc, pc and done stay frozen and no store occurs.
- R11: Read data appears on mem_rdata one cycle after mem_rd is sampled high. mem_rd and mem_we are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | ADDR_W | Word address presented to memory |
| mem_rd | output | 1 | Read request; data is returned on the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | DATA_W | Write data (the accumulator) |
| mem_rdata | input | DATA_W | Read data from the previous cycle's request |
| acc | output | DATA_W | Current accumulator value |
| pc | output | ADDR_W | Current program counter |
| done | output | 1 | High once a HALT has executed |
| div_err | output | 1 | Sticky division-by-zero flag |

## Verification
The bench builds the core with its default parameters: a 16-bit data word and an 11-bit address field, so the memory holds 2048 words. At this width the bench can place an ADD that wraps from the largest positive value to the most negative one, and a most-negative-by-minus-one division, inside a short program. It can also keep pointer words whose upper bits must be ignored. Both direct and pointer forms of every memory opcode can run alongside a skipped jump target, a no-op opcode and two zero divisors.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OPC_NOP   = 4'h0;
  localparam logic [OP_W-1:0] OPC_LOAD  = 4'h1;
  localparam logic [OP_W-1:0] OPC_STORE = 4'h2;
  localparam logic [OP_W-1:0] OPC_ADD   = 4'h3;
  localparam logic [OP_W-1:0] OPC_SUB   = 4'h4;
  localparam logic [OP_W-1:0] OPC_DIV   = 4'h5;
  localparam logic [OP_W-1:0] OPC_JMP   = 4'h6;
  localparam logic [OP_W-1:0] OPC_HALT  = 4'hF;

  typedef enum logic [2:0] {
    S_FETCH,
    S_DECODE,
    S_INDIRECT,
    S_EXECUTE,
    S_WRITEBACK,
    S_HALTED
  } core_state_e;

  // opcode needs a memory operand (read or write)
  function automatic logic uses_operand(input logic [OP_W-1:0] op);
    return (op == OPC_LOAD) || (op == OPC_STORE) || (op == OPC_ADD) ||
           (op == OPC_SUB)  || (op == OPC_DIV);
  endfunction

  // opcode reads its operand and updates the accumulator
  function automatic logic reads_operand(input logic [OP_W-1:0] op);
    return (op == OPC_LOAD) || (op == OPC_ADD) || (op == OPC_SUB) ||
           (op == OPC_DIV);
  endfunction

endpackage

// File: rtl/acc_core_alu.sv
module acc_core_alu
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] result,
  output logic              div_zero
);

  localparam int EXT_W = DATA_W + 1;

  // signed quotient truncated toward zero; one extra bit absorbs min / -1
  function automatic logic [DATA_W-1:0] sdiv_trunc(
    input logic [DATA_W-1:0] num,
    input logic [DATA_W-1:0] den
  );
    logic signed [EXT_W-1:0] n_ext;
    logic signed [EXT_W-1:0] d_ext;
    logic signed [EXT_W-1:0] quo;
    n_ext = {num[DATA_W-1], num};
    d_ext = {den[DATA_W-1], den};
    if (den == '0) quo = n_ext;
    else           quo = n_ext / d_ext;
    return quo[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] wrap_add(
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b
  );
    return a + b;
  endfunction

  function automatic logic [DATA_W-1:0] wrap_sub(
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b
  );
    return a - b;
  endfunction

  assign div_zero = (op == OPC_DIV) && (opnd == '0);

  always_comb begin
    case (op)
      OPC_LOAD: result = opnd;
      OPC_ADD:  result = wrap_add(acc_in, opnd);
      OPC_SUB:  result = wrap_sub(acc_in, opnd);
      OPC_DIV:  result = div_zero ? acc_in : sdiv_trunc(acc_in, opnd);
      default:  result = acc_in;
    endcase
  end

endmodule

// File: rtl/acc_core_ctrl.sv
module acc_core_ctrl
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rd_word,
  output core_state_e       state,
  output logic [OP_W-1:0]   ir_op,
  output logic              ir_ind,
  output logic [ADDR_W-1:0] ir_addr,
  output logic              pc_step,
  output logic              pc_jump,
  output logic [ADDR_W-1:0] jump_dest,
  output logic              acc_load,
  output logic              opnd_rd,
  output logic              opnd_wr
);

  localparam int IND_BIT = ADDR_W;
  localparam int OP_LO   = ADDR_W + 1;

  logic [OP_W-1:0]   dec_op;
  logic              dec_ind;
  logic [ADDR_W-1:0] dec_addr;
  core_state_e       state_nxt;

  assign dec_op   = rd_word[OP_LO +: OP_W];
  assign dec_ind  = rd_word[IND_BIT];
  assign dec_addr = rd_word[ADDR_W-1:0];

  always_comb begin
    state_nxt = state;
    case (state)
      S_FETCH:  state_nxt = S_DECODE;
      S_DECODE: begin
        if (dec_op == OPC_HALT)     state_nxt = S_HALTED;
        else if (uses_operand(dec_op))
          state_nxt = dec_ind ? S_INDIRECT : S_EXECUTE;
        else                        state_nxt = S_FETCH;
      end
      S_INDIRECT:  state_nxt = S_EXECUTE;
      S_EXECUTE:   state_nxt = reads_operand(ir_op) ? S_WRITEBACK : S_FETCH;
      S_WRITEBACK: state_nxt = S_FETCH;
      S_HALTED:    state_nxt = S_HALTED;
      default:     state_nxt = S_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_FETCH;
      ir_op   <= OPC_NOP;
      ir_ind  <= 1'b0;
      ir_addr <= '0;
    end else begin
      state <= state_nxt;
      if (state == S_DECODE) begin
        ir_op   <= dec_op;
        ir_ind  <= dec_ind;
        ir_addr <= dec_addr;
      end
    end
  end

  assign pc_step   = (state == S_DECODE) && (dec_op != OPC_HALT) && (dec_op != OPC_JMP);
  assign pc_jump   = (state == S_DECODE) && (dec_op == OPC_JMP);
  assign jump_dest = dec_addr;
  assign acc_load  = (state == S_WRITEBACK);
  assign opnd_rd   = (state == S_EXECUTE) && reads_operand(ir_op);
  assign opnd_wr   = (state == S_EXECUTE) && (ir_op == OPC_STORE);

endmodule

// File: rtl/acc_core_dp.sv
module acc_core_dp
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_step,
  input  logic              pc_jump,
  input  logic [ADDR_W-1:0] jump_dest,
  input  logic              acc_load,
  input  logic [OP_W-1:0]   ir_op,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] acc_q,
  output logic              err_q,
  output logic              div_zero
);

  logic [DATA_W-1:0] alu_y;

  acc_core_alu #(.DATA_W(DATA_W)) u_alu (
    .op       (ir_op),
    .acc_in   (acc_q),
    .opnd     (rd_word),
    .result   (alu_y),
    .div_zero (div_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      acc_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (pc_jump)      pc_q <= jump_dest;
      else if (pc_step) pc_q <= pc_q + 1'b1;
      if (acc_load) begin
        acc_q <= alu_y;
        if (div_zero) err_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] pc,
  output logic              done,
  output logic              div_err
);

  core_state_e       state;
  logic [OP_W-1:0]   ir_op;
  logic              ir_ind;
  logic [ADDR_W-1:0] ir_addr;
  logic              pc_step;
  logic              pc_jump;
  logic [ADDR_W-1:0] jump_dest;
  logic              acc_load;
  logic              opnd_rd;
  logic              opnd_wr;
  logic              div_zero;
  logic [ADDR_W-1:0] eff_addr;

  // named events for the checker
  logic ev_ind;
  logic ev_div_zero;

  acc_core_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_word   (mem_rdata),
    .state     (state),
    .ir_op     (ir_op),
    .ir_ind    (ir_ind),
    .ir_addr   (ir_addr),
    .pc_step   (pc_step),
    .pc_jump   (pc_jump),
    .jump_dest (jump_dest),
    .acc_load  (acc_load),
    .opnd_rd   (opnd_rd),
    .opnd_wr   (opnd_wr)
  );

  acc_core_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc_step   (pc_step),
    .pc_jump   (pc_jump),
    .jump_dest (jump_dest),
    .acc_load  (acc_load),
    .ir_op     (ir_op),
    .rd_word   (mem_rdata),
    .pc_q      (pc),
    .acc_q     (acc),
    .err_q     (div_err),
    .div_zero  (div_zero)
  );

  // after a pointer read the returned word is the operand address
  assign eff_addr = ir_ind ? mem_rdata[ADDR_W-1:0] : ir_addr;

  always_comb begin
    case (state)
      S_INDIRECT: mem_addr = ir_addr;
      S_EXECUTE:  mem_addr = eff_addr;
      default:    mem_addr = pc;
    endcase
  end

  assign mem_rd      = (state == S_FETCH) || (state == S_INDIRECT) || opnd_rd;
  assign mem_we      = opnd_wr;
  assign mem_wdata   = acc;
  assign done        = (state == S_HALTED);
  assign ev_ind      = (state == S_INDIRECT);
  assign ev_div_zero = acc_load && div_zero;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_we,
  input logic              done,
  input logic              div_err,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] acc,
  input logic              ev_ind,
  input logic              ev_div_zero
);

  assert_port_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we));

  assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && $stable(pc) && $stable(acc) && !mem_we);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |=> div_err);

  assert_divzero_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_div_zero |=> $stable(acc) && div_err);

  assert_ind_extra_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ind |=> (mem_rd || mem_we));

  assert_store_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we && mem_rd);

endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_rd      (mem_rd),
  .mem_we      (mem_we),
  .done        (done),
  .div_err     (div_err),
  .pc          (pc),
  .acc         (acc),
  .ev_ind      (ev_ind),
  .ev_div_zero (ev_div_zero)
);

// File: tb/acc_core_bench.sv
`timescale 1ns/1ps
module acc_core_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] mem_addr;
  logic        mem_rd;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic [15:0] acc;
  logic [10:0] pc;
  logic        done;
  logic        div_err;

  always #5 clk = ~clk;

  acc_core u_acc_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .acc(acc), .pc(pc), .done(done), .div_err(div_err)
  );

  logic [15:0] mem  [0:2047];
  logic [15:0] rmem [0:2047];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  bit cmp_on = 0;
  bit rhalt = 0;
  logic [15:0] exp_acc = '0;
  logic [10:0] exp_pc = '0;
  logic        exp_done = 0;
  logic        exp_err = 0;
  string       cur_req = "R1";

  task automatic put(input int a, input logic [15:0] v);
    mem[a] = v;
    rmem[a] = v;
  endtask

  function automatic logic [15:0] ins(input int op, input int ind, input int a);
    return {op[3:0], ind[0], a[10:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, expv);
    end
  endtask

  // behavioural reference: one instruction at a time, timed by the cycle counts of R2..R10
  task automatic ref_run();
    logic [15:0] w;
    logic [15:0] v;
    logic [3:0]  op;
    logic        ind;
    logic [10:0] a;
    logic [10:0] ea;
    int          q;
    while (!rhalt) begin
      w = rmem[exp_pc]; op = w[15:12]; ind = w[11]; a = w[10:0];
      if (op == 4'hF)                 cur_req = "R10";
      else if (op == 4'h6)            cur_req = "R9";
      else if (op == 0 || op > 4'h6)  cur_req = "R2";
      else if (ind)                   cur_req = "R6";
      else if (op == 4'h2)            cur_req = "R4";
      else if (op == 4'h5)            cur_req = "R7/R8";
      else                            cur_req = "R3/R5";
      @(posedge clk); @(posedge clk); #1;
      if (op == 4'hF) begin
        exp_done = 1'b1;
        rhalt = 1'b1;
      end else if (op == 4'h6) exp_pc = a;
      else exp_pc = exp_pc + 11'd1;
      if (op >= 4'h1 && op <= 4'h5) begin
        ea = a;
        if (ind) begin
          @(posedge clk); #1;
          ea = rmem[a][10:0];
        end
        if (op == 4'h2) begin
          @(posedge clk); #1;
          rmem[ea] = exp_acc;
        end else begin
          @(posedge clk); @(posedge clk); #1;
          v = rmem[ea];
          case (op)
            4'h1: exp_acc = v;
            4'h3: exp_acc = exp_acc + v;
            4'h4: exp_acc = exp_acc - v;
            default: begin
              if (v == 16'h0) exp_err = 1'b1;
              else begin
                q = int'($signed(exp_acc)) / int'($signed(v));
                exp_acc = q[15:0];
              end
            end
          endcase
        end
      end
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      tests++;
      if (acc !== exp_acc || pc !== exp_pc || done !== exp_done || div_err !== exp_err) begin
        fails++;
        $display("FAIL %s acc %h/%h pc %h/%h done %b/%b err %b/%b (actual/expected)",
                 cur_req, acc, exp_acc, pc, exp_pc, done, exp_done, div_err, exp_err);
      end
      tests++;
      if (mem_rd && mem_we) begin
        fails++;
        $display("FAIL R11 rd&we actual 1 expected 0");
      end
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) put(i, 16'h0);
    // data
    put(16'h100, 16'd100);
    put(16'h101, 16'd23);
    put(16'h102, 16'hF903);   // pointer -> 0x103, upper bits ignored (R6)
    put(16'h103, 16'hFFF9);   // -7
    put(16'h104, 16'd2);
    put(16'h105, 16'd0);
    put(16'h106, 16'h7FFF);
    put(16'h107, 16'd1);
    put(16'h108, 16'h8000);
    put(16'h109, 16'hFFFF);
    put(16'h10A, 16'h0110);
    put(16'h10B, 16'h0105);
    // program
    put(0,  ins(1, 0, 'h100));  // LOAD 100
    put(1,  ins(3, 0, 'h101));  // ADD -> 123
    put(2,  ins(4, 0, 'h104));  // SUB -> 121
    put(3,  ins(2, 0, 'h111));  // STORE
    put(4,  ins(1, 1, 'h102));  // LOAD @ -> -7
    put(5,  ins(5, 0, 'h104));  // DIV -> -3
    put(6,  ins(3, 1, 'h102));  // ADD @ -> -10
    put(7,  ins(5, 0, 'h105));  // DIV 0 -> err
    put(8,  ins(2, 1, 'h10A));  // STORE @ -> [110]
    put(9,  ins(1, 0, 'h106));  // LOAD 7FFF
    put(10, ins(3, 0, 'h107));  // ADD wrap -> 8000
    put(11, ins(5, 0, 'h109));  // DIV -1 -> 8000
    put(12, ins(6, 0, 14));     // JMP 14
    put(13, ins(1, 0, 'h101));  // skipped
    put(14, ins(9, 1, 'h101));  // no-op opcode
    put(15, ins(5, 0, 'h104));  // DIV 2 -> C000
    put(16, ins(5, 1, 'h10B));  // DIV @ zero
    put(17, ins(2, 0, 'h112));  // STORE
    put(18, ins(15, 0, 0));     // HALT
    put(19, ins(1, 0, 'h100));  // never runs

    repeat (3) @(negedge clk);
    chk("R1 pc", 32'(pc), 0);
    chk("R1 acc", 32'(acc), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 div_err", 32'(div_err), 0);
    chk("R1 mem_we", 32'(mem_we), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    ref_run();
    repeat (20) @(negedge clk);
    cmp_on = 1'b0;
    chk("R4 direct store", 32'(mem[16'h111]), 32'h0079);
    chk("R6 pointer store", 32'(mem[16'h110]), 32'hFFF6);
    chk("R7 final quotient stored", 32'(mem[16'h112]), 32'hC000);
    chk("R8 final acc", 32'(acc), 32'hC000);
    chk("R8 err sticky", 32'(div_err), 1);
    chk("R9 skipped target untouched", 32'(mem[16'h113]), 0);
    chk("R10 pc frozen", 32'(pc), 18);
    chk("R10 done", 32'(done), 1);
    chk("R2 data untouched", 32'(mem[16'h101]), 23);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL R10 watchdog: done actual %b expected 1", done);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule